// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits between a set of device interrupt request lines and a single CPU interrupt input. It accepts up to eight level-sensitive maskable requests plus one non-maskable request. Request lines are ranked by their line number, and line 0 is the most urgent. The block asserts one interrupt output whenever a request exists that outranks the level now in service. When the CPU acknowledges, the block returns the winning line number and that source's programmed vector, which the CPU uses to index its handler table. The level of the accepted source becomes the new level in service, and the level it replaced is saved on a small internal stack.

Software programs a vector for each source and for the non-maskable source through a simple write port. An end-of-interrupt write to the same port pops the saved level back. This allows nested handling: a more urgent source can interrupt a handler, and each end-of-interrupt unwinds one level. The non-maskable request is edge-triggered and bypasses the level mask. It is held off only while a non-maskable handler is itself in service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), int_o and ack_valid_o are 0 and cur_level_o is 9, the idle value. The vector of source i is reset to 0x20+i, and the non-maskable vector is reset to 0x28.
- R2: The level code is 0 for the non-maskable source and i+1 for request line i. A lower code is more urgent. int_o is combinational and is 1 in the same cycle that some irq_i[i] is high with i+1 < cur_level_o, or that a non-maskable request is pending while cur_level_o is not 0.
- R3: When ack_i is high at a clock edge and int_o is 1, ack_valid_o is 1 for the following cycle. A pending non-maskable request wins, giving ack_nmi_o=1 and ack_num_o=0. Otherwise the lowest-numbered allowed line wins, giving ack_nmi_o=0 and ack_num_o equal to that line number.
- R4: ack_vec_o carries the vector register of the winner. A write to address i (0 to 7) sets the vector of source i. A write to address 8 sets the non-maskable vector. The new value is used by later acknowledges.
- R5: On an accepted acknowledge, cur_level_o takes the level code of the winner in the next cycle, and the previous level is saved.
- R6: A request line whose level code is equal to or greater than cur_level_o does not raise int_o.
- R7: A write to address 9 is an end-of-interrupt. It restores the most recently saved level in the next cycle. With nothing in service, cur_level_o stays at 9.
- R8: A rising edge on nmi_i is latched as pending, and int_o rises in the following cycle. The pending request is cleared on its acknowledge. A level held high on nmi_i raises no further request. No new non-maskable request is delivered while cur_level_o is 0.
- R9: ack_i while int_o is 0 produces no ack_valid_o and leaves cur_level_o unchanged.
- R10: The data written with an end-of-interrupt is ignored, and such a write alters no vector register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_i | input | 8 | Level-sensitive maskable requests; bit 0 most urgent |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| ack_i | input | 1 | CPU interrupt acknowledge |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | 0-7 source vector, 8 non-maskable vector, 9 end-of-interrupt |
| wr_data_i | input | 8 | Write data |
| int_o | output | 1 | Interrupt request to the CPU |
| ack_valid_o | output | 1 | One-cycle pulse: acknowledge result is valid |
| ack_nmi_o | output | 1 | Accepted source is the non-maskable one |
| ack_num_o | output | 3 | Encoded accepted line number |
| ack_vec_o | output | 8 | Vector of the accepted source |
| cur_level_o | output | 4 | Level currently in service (9 = idle) |

## Verification
A corrupted level register or saved-level stack shows up at the ports in two ways. cur_level_o reads back the wrong value in the cycle after an acknowledge or end-of-interrupt, and int_o then rises or stays low for the wrong request pattern in that same cycle. A bad winner selection or vector register appears as a wrong ack_num_o or ack_vec_o on the ack_valid_o pulse, one cycle after the acknowledge. A lost or stuck pending non-maskable flag appears on int_o one cycle after the nmi_i edge, or after the end-of-interrupt that should leave it quiet. The stimulus therefore nests three levels deep, unwinds past empty, and reads each result in the first cycle it can change.

// File: rtl/viq_pkg.sv
// Shared definitions for the vectored interrupt controller.
// Assumes the write address space is laid out as: source vectors first,
// then the non-maskable vector, then the end-of-interrupt command.
package viq_pkg;

    typedef enum logic [1:0] {
        WK_NONE    = 2'd0,
        WK_SRC_VEC = 2'd1,
        WK_NMI_VEC = 2'd2,
        WK_EOI     = 2'd3
    } wr_kind_e;

    // Classify a write address for a controller with n maskable sources.
    function automatic wr_kind_e wr_decode(input int unsigned addr, input int unsigned n);
        if (addr < n)            return WK_SRC_VEC;
        else if (addr == n)      return WK_NMI_VEC;
        else if (addr == n + 1)  return WK_EOI;
        else                     return WK_NONE;
    endfunction

endpackage

// File: rtl/viq_arbiter.sv
// Fixed-priority selector. Picks the lowest-numbered request line whose
// level code (line+1) is strictly below the level in service. A pending
// non-maskable request wins outright unless level 0 is already in service.
// Purely combinational; assumes NUM_SRC >= 2.
module viq_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int SRC_W   = 3,
    parameter int LVL_W   = 4
) (
    input  logic [NUM_SRC-1:0] irq,
    input  logic               nmi_pend,
    input  logic [LVL_W-1:0]   cur_level,
    output logic               hit,
    output logic               win_nmi,
    output logic [SRC_W-1:0]   win_num,
    output logic [LVL_W-1:0]   win_level
);

    logic             mask_hit;
    logic [SRC_W-1:0] mask_num;

    // Scan from least to most urgent so the most urgent allowed line wins.
    always_comb begin
        mask_hit = 1'b0;
        mask_num = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (irq[i] && (LVL_W'(i + 1) < cur_level)) begin
                mask_hit = 1'b1;
                mask_num = SRC_W'(i);
            end
        end
    end

    // Let the non-maskable request override the maskable winner.
    always_comb begin
        win_nmi = nmi_pend && (cur_level != '0);
        hit     = win_nmi || mask_hit;
        if (win_nmi) begin
            win_num   = '0;
            win_level = '0;
        end else begin
            win_num   = mask_num;
            win_level = LVL_W'(mask_num) + LVL_W'(1);
        end
    end

endmodule

// File: rtl/viq_level_stack.sv
// Priority register plus a stack of saved levels. A push saves the current
// level and installs a more urgent one. A pop restores the last saved
// level; a pop on an empty stack is ignored. A push takes precedence over
// a pop in the same cycle. Assumes every push installs a strictly lower
// code, so DEPTH = number of codes below idle can never overflow.
module viq_level_stack #(
    parameter int              LVL_W    = 4,
    parameter int              DEPTH    = 9,
    parameter logic [LVL_W-1:0] IDLE_LVL = 4'd9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_level,
    input  logic             pop,
    output logic [LVL_W-1:0] cur_level
);

    localparam int SP_W = $clog2(DEPTH + 1);

    logic [LVL_W-1:0] mem [2**SP_W];
    logic [SP_W-1:0]  sp;

    // Store the outgoing level at the stack pointer on a push.
    always_ff @(posedge clk) begin
        if (push) mem[sp] <= cur_level;
    end

    // Track the level in service and the stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp        <= '0;
            cur_level <= IDLE_LVL;
        end else if (push) begin
            sp        <= sp + 1'b1;
            cur_level <= push_level;
        end else if (pop && (sp != '0)) begin
            sp        <= sp - 1'b1;
            cur_level <= mem[sp - 1'b1];
        end
    end

    a_r5_stack_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (sp < SP_W'(DEPTH)));

    a_r5_level_drops: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (cur_level < $past(cur_level)));

    a_r7_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (sp == '0) |-> (cur_level == IDLE_LVL));

    a_r7_empty_pop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && (sp == '0)) |=> (cur_level == IDLE_LVL));

endmodule

// File: rtl/viq_vector_file.sv
// Programmable vector registers: one per maskable source plus one for the
// non-maskable source at index NUM_SRC. Entry g resets to VEC_BASE+g.
// Read is combinational; a write shows on the read port one cycle later.
module viq_vector_file #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32,
    parameter int IDX_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VEC_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VEC_W-1:0] rd_vec
);

    logic [VEC_W-1:0] regs [NUM_SRC+1];

    for (genvar g = 0; g <= NUM_SRC; g++) begin : g_vec
        // Hold one vector; reload its reset value or take a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= VEC_W'(VEC_BASE + g);
            else if (wr_en && (wr_idx == IDX_W'(g)))
                regs[g] <= wr_data;
        end
    end

    assign rd_vec = regs[rd_idx];

endmodule

// File: rtl/vec_irq_ctrl.sv
// Prioritised vectored interrupt controller top. Combines the selector,
// the level stack and the vector file; latches non-maskable edges and
// registers the acknowledge result for one cycle. Assumes the CPU holds
// ack_i for one cycle per acknowledge and issues one end-of-interrupt per
// accepted source.
module vec_irq_ctrl #(
    parameter int NUM_SRC  = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               irq_i,
    input  logic                             nmi_i,
    input  logic                             ack_i,
    input  logic                             wr_en_i,
    input  logic [$clog2(NUM_SRC+2)-1:0]     wr_addr_i,
    input  logic [VEC_W-1:0]                 wr_data_i,
    output logic                             int_o,
    output logic                             ack_valid_o,
    output logic                             ack_nmi_o,
    output logic [$clog2(NUM_SRC)-1:0]       ack_num_o,
    output logic [VEC_W-1:0]                 ack_vec_o,
    output logic [$clog2(NUM_SRC+2)-1:0]     cur_level_o
);
    import viq_pkg::*;

    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int LVL_W  = $clog2(NUM_SRC + 2);
    localparam int ADDR_W = $clog2(NUM_SRC + 2);
    localparam int IDX_W  = $clog2(NUM_SRC + 1);
    localparam int DEPTH  = NUM_SRC + 1;
    localparam logic [LVL_W-1:0] IDLE_LVL = LVL_W'(NUM_SRC + 1);

    logic             nmi_q, nmi_pend;
    logic             hit, win_nmi, accept;
    logic [SRC_W-1:0] win_num;
    logic [LVL_W-1:0] win_level, cur_level;
    logic [VEC_W-1:0] win_vec;
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic             vec_we, eoi;
    wr_kind_e         kind;

    // Classify the write port access.
    always_comb begin
        kind   = wr_decode(int'(wr_addr_i), NUM_SRC);
        vec_we = wr_en_i && ((kind == WK_SRC_VEC) || (kind == WK_NMI_VEC));
        eoi    = wr_en_i && (kind == WK_EOI);
        wr_idx = (kind == WK_SRC_VEC) ? IDX_W'(wr_addr_i) : IDX_W'(NUM_SRC);
        rd_idx = win_nmi ? IDX_W'(NUM_SRC) : IDX_W'(win_num);
    end

    assign accept = ack_i && hit;
    assign int_o  = hit;

    // Latch a rising edge of the non-maskable input until it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            if (nmi_i && !nmi_q)
                nmi_pend <= 1'b1;
            else if (accept && win_nmi)
                nmi_pend <= 1'b0;
        end
    end

    // Register the acknowledge result for the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid_o <= 1'b0;
            ack_nmi_o   <= 1'b0;
            ack_num_o   <= '0;
            ack_vec_o   <= '0;
        end else begin
            ack_valid_o <= accept;
            if (accept) begin
                ack_nmi_o <= win_nmi;
                ack_num_o <= win_num;
                ack_vec_o <= win_vec;
            end
        end
    end

    viq_arbiter #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .LVL_W(LVL_W)) u_arb (
        .irq       (irq_i),
        .nmi_pend  (nmi_pend),
        .cur_level (cur_level),
        .hit       (hit),
        .win_nmi   (win_nmi),
        .win_num   (win_num),
        .win_level (win_level)
    );

    viq_level_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH), .IDLE_LVL(IDLE_LVL)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (accept),
        .push_level (win_level),
        .pop        (eoi),
        .cur_level  (cur_level)
    );

    viq_vector_file #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE),
                      .IDX_W(IDX_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_we),
        .wr_idx  (wr_idx),
        .wr_data (wr_data_i),
        .rd_idx  (rd_idx),
        .rd_vec  (win_vec)
    );

    assign cur_level_o = cur_level;

    a_r3_ack_needs_int: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> $past(ack_i && int_o));

    a_r6_winner_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && !ack_nmi_o) |-> ((LVL_W'(ack_num_o) + LVL_W'(1)) < $past(cur_level)));

    a_r8_nmi_not_nested: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid_o && ack_nmi_o) |-> ($past(cur_level) != '0));

    a_r5_level_matches_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid_o |-> (cur_level == (ack_nmi_o ? '0 : LVL_W'(ack_num_o) + LVL_W'(1))));

    a_r9_no_ack_without_int: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !int_o && !eoi) |=> (!ack_valid_o && $stable(cur_level)));

endmodule

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       nmi = 1'b0, ack = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       int_o, ack_valid, ack_nmi;
    logic [2:0] ack_num;
    logic [7:0] ack_vec;
    logic [3:0] cur_level;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl i_vec_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .nmi_i(nmi), .ack_i(ack),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .int_o(int_o), .ack_valid_o(ack_valid), .ack_nmi_o(ack_nmi),
        .ack_num_o(ack_num), .ack_vec_o(ack_vec), .cur_level_o(cur_level)
    );

    // Fields: irq[26:19] op[18:17] (0 idle,1 ack,2 eoi) int[16] valid[15]
    // num[14:12] vec[11:4] level[3:0]
    localparam int NV = 16;
    localparam logic [26:0] TBL [NV] = '{
        {8'h00, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9},  // R2 quiet
        {8'h20, 2'd1, 1'b1, 1'b1, 3'd5, 8'h25, 4'd6},  // R3 R5 line 5
        {8'h60, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00, 4'd6},  // R6 equal/lower masked
        {8'h64, 2'd1, 1'b1, 1'b1, 3'd2, 8'h22, 4'd3},  // R3 nested line 2
        {8'h08, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00, 4'd3},  // R6 line 3 masked
        {8'h08, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00, 4'd6},  // R7 pop to 6
        {8'h08, 2'd1, 1'b1, 1'b1, 3'd3, 8'h23, 4'd4},  // R3 line 3
        {8'h00, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00, 4'd6},  // R7
        {8'h00, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9},  // R7 back to idle
        {8'h00, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9},  // R7 empty pop
        {8'h00, 2'd1, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9},  // R9 ack without int
        {8'h81, 2'd1, 1'b1, 1'b1, 3'd0, 8'h20, 4'd1},  // R3 line 0 beats 7
        {8'h81, 2'd0, 1'b0, 1'b0, 3'd0, 8'h00, 4'd1},  // R6 all masked
        {8'h00, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9},  // R7
        {8'h80, 2'd1, 1'b1, 1'b1, 3'd7, 8'h27, 4'd8},  // R3 least urgent
        {8'h00, 2'd2, 1'b0, 1'b0, 3'd0, 8'h00, 4'd9}   // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present inputs at a falling edge, hold for one rising edge, release.
    task automatic cyc(input logic [7:0] r, input logic a, input logic w,
                       input logic [3:0] ad, input logic [7:0] d);
        irq = r; ack = a; wr_en = w; wr_addr = ad; wr_data = d;
        @(negedge clk);
        ack = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check("R1 int", int_o, 0);
        check("R1 valid", ack_valid, 0);
        check("R1 level", cur_level, 9);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            logic [26:0] e;
            e = TBL[k];
            irq = e[26:19];
            #1 check("R2 int_o", int_o, e[16]);
            cyc(e[26:19], e[18:17] == 2'd1, e[18:17] == 2'd2, 4'd9, 8'h00);
            check("R3 valid", ack_valid, e[15]);
            if (e[15]) begin
                check("R3 num", ack_num, e[14:12]);
                check("R3 nmi flag", ack_nmi, 0);
                check("R4 vector", ack_vec, e[11:4]);
            end
            check("R5 level", cur_level, e[3:0]);
        end

        // R4 R10: program source 3, EOI data ignored
        cyc(8'h00, 0, 1, 4'd3, 8'h5A);
        cyc(8'h00, 0, 1, 4'd9, 8'hFF);
        check("R10 level after empty eoi", cur_level, 9);
        cyc(8'h08, 1, 0, 4'd0, 8'h00);
        check("R4 programmed vector", ack_vec, 8'h5A);
        check("R10 eoi wrote no vector", ack_num, 3);
        cyc(8'h00, 0, 1, 4'd9, 8'h00);

        // R8: non-maskable request over line 0
        cyc(8'h01, 1, 0, 4'd0, 8'h00);
        check("R5 level line0", cur_level, 1);
        nmi = 1'b1;
        @(negedge clk);
        check("R8 int after edge", int_o, 1);
        cyc(8'h01, 1, 0, 4'd0, 8'h00);
        check("R8 nmi flag", ack_nmi, 1);
        check("R8 nmi num", ack_num, 0);
        check("R4 nmi vector", ack_vec, 8'h28);
        check("R8 level nmi", cur_level, 0);
        check("R8 held level no request", int_o, 0);
        cyc(8'h01, 0, 1, 4'd9, 8'h00);
        check("R7 restore line0", cur_level, 1);
        check("R8 no re-request", int_o, 0);
        cyc(8'h00, 0, 1, 4'd9, 8'h00);
        nmi = 1'b0;
        check("R7 idle", cur_level, 9);

        // R4: program the non-maskable vector, then pulse
        cyc(8'h00, 0, 1, 4'd8, 8'h77);
        nmi = 1'b1;
        @(negedge clk);
        nmi = 1'b0;
        check("R8 pending latched", int_o, 1);
        cyc(8'h00, 1, 0, 4'd0, 8'h00);
        check("R4 new nmi vector", ack_vec, 8'h77);
        check("R8 cleared on ack", int_o, 0);
        cyc(8'h00, 0, 1, 4'd9, 8'h00);

        // R1: reset mid-run restores vectors and level
        cyc(8'h00, 0, 1, 4'd3, 8'h11);
        cyc(8'h08, 1, 0, 4'd0, 8'h00);
        rst_n = 1'b0;
        irq = 8'h00;
        @(negedge clk);
        check("R1 level after reset", cur_level, 9);
        check("R1 valid after reset", ack_valid, 0);
        rst_n = 1'b1;
        cyc(8'h08, 1, 0, 4'd0, 8'h00);
        check("R1 default vector", ack_vec, 8'h23);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule